// File: doc/BRIEF.md
# Double-Buffered DAC Input Register Front End

This block is the synchronous digital front end of a 16-bit digital-to-analog converter. A host writes over an 8-bit bus that is qualified by an active-low chip select and an active-low write strobe. Two active-low lane enables choose which half of a 16-bit staging register a write fills. Asserting both lane enables together selects serial loading, and the word then enters one bit at a time on bus bit 0.

A separate active-low transfer enable copies the staging register into the converter register, which drives the code presented to the analog core. This double buffering lets the host assemble a new word without disturbing the current output. It also lets the host update several converters at the same moment.

A synchronous active-low clear empties the staging register. It also returns the converter register to the mid-scale code that gives zero output in bipolar operation. When the mode input selects unipolar operation, the most significant bit is inverted on its way to the output.

Top module: `dac_dbuf_frontend`

## Requirements
- R1: A qualified write (cs_n=0, wr_n=0, clr_n=1) with lo_en_n=0 and hi_en_n=1 loads bus_d[7:0] into staging bits 7..0 at the clock edge and leaves bits 15..8 unchanged.
- R2: A qualified write with hi_en_n=0 and lo_en_n=1 loads bus_d[7:0] into staging bits 15..8 and leaves bits 7..0 unchanged.
- R3: A qualified write with lo_en_n=0 and hi_en_n=0 shifts the staging register left by one place, with bus_d[0] entering bit 0 and the other bus bits ignored. Sixteen such writes load a word sent MSB first.
- R4: A qualified write with xfer_en_n=0 copies the staging register into the converter register. If a staging load happens in the same cycle, the copy takes the staging value from before that load. dac_code changes only through a transfer, clear or reset.
- R5: While cs_n=1 or wr_n=1, no staging load and no transfer takes place.
- R6: A cycle with clr_n=0 sets the staging register to 16'h0000 and the converter register to 16'h8000. This takes priority over any write or transfer in that cycle.
- R7: With unipolar=0, dac_code equals the converter register. With unipolar=1, dac_code is the converter register with bit 15 inverted, so a cleared converter reads 16'h0000.
- R8: With rst_n=0, the block takes the same state as a clear: staging 16'h0000 and converter 16'h8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| lo_en_n | input | 1 | Low-lane enable, active low |
| hi_en_n | input | 1 | High-lane enable, active low |
| xfer_en_n | input | 1 | Staging-to-converter transfer enable, active low |
| clr_n | input | 1 | Synchronous clear, active low |
| unipolar | input | 1 | 1 selects unipolar coding (MSB inverted) |
| bus_d | input | 8 | Data bus; bit 0 carries serial data |
| dac_code | output | 16 | Code presented to the converter core |

## Verification
A staging load and a transfer can share one qualified write cycle. The bench provokes this by loading a new low byte while the transfer enable is low. The converter must then show the old staging word, and a second transfer must show the updated word. A clear can also coincide with a lane write and a transfer. In that case the bench judges that the clear wins, from the mid-scale code at the output and from the all-zero word that the next transfer delivers.

// File: rtl/dac_fe_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and derived constants for the DAC front end.
package dac_fe_pkg;
    parameter int CODE_W = 16;
    parameter int LANE_W = 8;
    localparam int N_LANES = CODE_W / LANE_W;
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
endpackage

// File: rtl/dac_wr_decode.sv
`timescale 1ns/1ps
// dac_wr_decode: turns the active-low control pins into qualified actions.
// Assumes all control inputs are synchronous to clk.
module dac_wr_decode #(
    parameter int N_LANES = 2
) (
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic [N_LANES-1:0] lane_en_n,
    input  logic               xfer_en_n,
    output logic               wr_q,
    output logic               serial_sel,
    output logic [N_LANES-1:0] lane_sel,
    output logic               xfer_q
);
    // Purpose: qualify strobe, detect serial mode, decode lane loads.
    always_comb begin
        wr_q       = ~cs_n & ~wr_n;
        serial_sel = ~(|lane_en_n);
        lane_sel   = serial_sel ? '0 : ~lane_en_n;
        xfer_q     = wr_q & ~xfer_en_n;
    end
endmodule

// File: rtl/dac_in_reg.sv
`timescale 1ns/1ps
// dac_in_reg: staging register loaded lane by lane or serially, MSB first.
// Assumes clear has priority over any load.
module dac_in_reg #(
    parameter int CODE_W = 16,
    parameter int LANE_W = 8,
    localparam int N_LANES = CODE_W / LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               wr_q,
    input  logic               serial_sel,
    input  logic [N_LANES-1:0] lane_sel,
    input  logic [LANE_W-1:0]  bus_d,
    output logic [CODE_W-1:0]  word
);
    logic [CODE_W-1:0] word_nxt;

    // Purpose: compute the next staging value from the selected load.
    always_comb begin
        word_nxt = word;
        if (wr_q) begin
            if (serial_sel) begin
                word_nxt = {word[CODE_W-2:0], bus_d[0]};
            end else begin
                for (int ln = 0; ln < N_LANES; ln++) begin
                    if (lane_sel[ln]) word_nxt[ln*LANE_W +: LANE_W] = bus_d;
                end
            end
        end
    end

    // Purpose: hold the staging word; reset and clear zero it.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) word <= '0;
        else                  word <= word_nxt;
    end
endmodule

// File: rtl/dac_conv_reg.sv
`timescale 1ns/1ps
// dac_conv_reg: converter register, second stage of the double buffer.
// Assumes the caller passes the staging value from before this edge.
module dac_conv_reg #(
    parameter int CODE_W = 16,
    parameter logic [CODE_W-1:0] CLR_CODE = {1'b1, {(CODE_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              xfer_q,
    input  logic [CODE_W-1:0] stage_word,
    output logic [CODE_W-1:0] conv_word
);
    // Purpose: take the staging word on transfer; go to mid-scale on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) conv_word <= CLR_CODE;
        else if (xfer_q)      conv_word <= stage_word;
    end
endmodule

// File: rtl/dac_code_map.sv
`timescale 1ns/1ps
// dac_code_map: output coding; unipolar mode inverts the MSB.
// Assumes offset-binary coding in the converter register.
module dac_code_map #(
    parameter int CODE_W = 16
) (
    input  logic              unipolar,
    input  logic [CODE_W-1:0] conv_word,
    output logic [CODE_W-1:0] dac_code
);
    // Purpose: apply the mode-dependent MSB inversion.
    always_comb dac_code = {conv_word[CODE_W-1] ^ unipolar, conv_word[CODE_W-2:0]};
endmodule

// File: rtl/dac_dbuf_frontend.sv
`timescale 1ns/1ps
// dac_dbuf_frontend: double-buffered register front end for a 16-bit DAC.
// Assumes synchronous control pins, with clear and reset acting on clk.
module dac_dbuf_frontend
    import dac_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic              xfer_en_n,
    input  logic              clr_n,
    input  logic              unipolar,
    input  logic [LANE_W-1:0] bus_d,
    output logic [CODE_W-1:0] dac_code
);
    logic               wr_q;
    logic               serial_sel;
    logic               xfer_q;
    logic [N_LANES-1:0] lane_sel;
    logic [CODE_W-1:0]  in_word;
    logic [CODE_W-1:0]  conv_word;

    dac_wr_decode #(.N_LANES(N_LANES)) dec_i (
        .cs_n(cs_n), .wr_n(wr_n), .lane_en_n({hi_en_n, lo_en_n}),
        .xfer_en_n(xfer_en_n), .wr_q(wr_q), .serial_sel(serial_sel),
        .lane_sel(lane_sel), .xfer_q(xfer_q)
    );

    dac_in_reg #(.CODE_W(CODE_W), .LANE_W(LANE_W)) stg_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_q(wr_q),
        .serial_sel(serial_sel), .lane_sel(lane_sel), .bus_d(bus_d),
        .word(in_word)
    );

    dac_conv_reg #(.CODE_W(CODE_W), .CLR_CODE(MID_CODE)) conv_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .xfer_q(xfer_q),
        .stage_word(in_word), .conv_word(conv_word)
    );

    dac_code_map #(.CODE_W(CODE_W)) map_i (
        .unipolar(unipolar), .conv_word(conv_word), .dac_code(dac_code)
    );
endmodule

// File: rtl/dac_dbuf_chk.sv
`timescale 1ns/1ps
// dac_dbuf_chk: temporal checks on the front end, bound to the top module.
module dac_dbuf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        wr_n,
    input logic        lo_en_n,
    input logic        hi_en_n,
    input logic        xfer_en_n,
    input logic        clr_n,
    input logic [7:0]  bus_d,
    input logic [15:0] in_word,
    input logic [15:0] conv_word
);
    // R6
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (in_word == 16'h0000 && conv_word == 16'h8000));
    // R5
    unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && (cs_n || wr_n)) |=> ($stable(in_word) && $stable(conv_word)));
    // R4
    xfer_old_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !cs_n && !wr_n && !xfer_en_n) |=> conv_word == $past(in_word));
    // R3
    serial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !cs_n && !wr_n && !lo_en_n && !hi_en_n)
        |=> in_word == {$past(in_word[14:0]), $past(bus_d[0])});
    // R1
    low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !cs_n && !wr_n && !lo_en_n && hi_en_n)
        |=> (in_word[7:0] == $past(bus_d) && $stable(in_word[15:8])));
    // R2
    high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !cs_n && !wr_n && lo_en_n && !hi_en_n)
        |=> (in_word[15:8] == $past(bus_d) && $stable(in_word[7:0])));
endmodule

bind dac_dbuf_frontend dac_dbuf_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .lo_en_n(lo_en_n),
    .hi_en_n(hi_en_n), .xfer_en_n(xfer_en_n), .clr_n(clr_n), .bus_d(bus_d),
    .in_word(in_word), .conv_word(conv_word)
);

// File: tb/dac_dbuf_frontend_tb_top.sv
`timescale 1ns/1ps
module dac_dbuf_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, lo_en_n = 1'b1, hi_en_n = 1'b1;
    logic        xfer_en_n = 1'b1, clr_n = 1'b1, unipolar = 1'b0;
    logic [7:0]  bus_d = 8'h00;
    logic [15:0] dac_code;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dac_dbuf_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .lo_en_n(lo_en_n),
        .hi_en_n(hi_en_n), .xfer_en_n(xfer_en_n), .clr_n(clr_n),
        .unipolar(unipolar), .bus_d(bus_d), .dac_code(dac_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of controls at a falling edge; return at the next falling edge.
    task automatic cyc(input logic cs, input logic wr, input logic lo, input logic hi,
                       input logic xf, input logic clr, input logic [7:0] d);
        cs_n = cs; wr_n = wr; lo_en_n = lo; hi_en_n = hi;
        xfer_en_n = xf; clr_n = clr; bus_d = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; lo_en_n = 1'b1; hi_en_n = 1'b1;
        xfer_en_n = 1'b1; clr_n = 1'b1;
    endtask

    task automatic do_xfer();
        cyc(0, 0, 1, 1, 0, 1, 8'h00);
    endtask

    task automatic t_reset();
        unipolar = 1'b0;
        check("R8 reset bipolar", dac_code, 16'h8000);
        unipolar = 1'b1; #0.1;
        check("R7 reset unipolar", dac_code, 16'h0000);
        unipolar = 1'b0;
    endtask

    task automatic t_lanes();
        cyc(0, 0, 0, 1, 1, 1, 8'h34);
        cyc(0, 0, 1, 0, 1, 1, 8'h12);
        check("R4 no output change before transfer", dac_code, 16'h8000);
        do_xfer();
        check("R1 R2 lane loads", dac_code, 16'h1234);
        cyc(0, 0, 1, 0, 1, 1, 8'h9A);
        do_xfer();
        check("R2 high lane keeps low", dac_code, 16'h9A34);
        cyc(0, 0, 0, 1, 1, 1, 8'h12);
        do_xfer();
        check("R1 low lane keeps high", dac_code, 16'h9A12);
    endtask

    task automatic t_unqualified();
        cyc(1, 0, 0, 1, 0, 1, 8'hFF);
        check("R5 cs_n high blocks transfer", dac_code, 16'h9A12);
        cyc(0, 1, 1, 0, 0, 1, 8'hEE);
        check("R5 wr_n high blocks transfer", dac_code, 16'h9A12);
        do_xfer();
        check("R5 no staging load while unqualified", dac_code, 16'h9A12);
    endtask

    task automatic t_same_cycle();
        cyc(0, 0, 0, 1, 0, 1, 8'hAB);
        check("R4 transfer uses pre-load word", dac_code, 16'h9A12);
        do_xfer();
        check("R4 later transfer sees new byte", dac_code, 16'h9AAB);
    endtask

    task automatic t_serial(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) cyc(0, 0, 0, 0, 1, 1, {7'h5B, w[i]});
        check("R3 serial before transfer", dac_code, 16'h9AAB);
        do_xfer();
        check("R3 serial word", dac_code, w);
    endtask

    task automatic t_unipolar();
        unipolar = 1'b1; #0.1;
        check("R7 unipolar MSB inverted", dac_code, 16'h43A5);
        unipolar = 1'b0; #0.1;
        check("R7 bipolar passthrough", dac_code, 16'hC3A5);
    endtask

    task automatic t_clear();
        cyc(0, 0, 1, 0, 0, 0, 8'h55);
        check("R6 clear beats write and transfer", dac_code, 16'h8000);
        do_xfer();
        check("R6 staging zeroed by clear", dac_code, 16'h0000);
        cyc(1, 1, 1, 1, 1, 0, 8'h00);
        unipolar = 1'b1; #0.1;
        check("R6 R7 cleared unipolar", dac_code, 16'h0000);
        unipolar = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_unqualified();
        t_same_cycle();
        t_serial(16'hC3A5);
        t_unipolar();
        t_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule